// File: doc/BRIEF.md
# Comparator Offset Trim Search Controller

This block calibrates away the input offset of a clocked comparator before the comparator is put to stochastic use. A calibration is a separate phase: while it runs, the block holds an input-short control high so that both comparator inputs sit at the common-mode level. With no real signal present, every decision the comparator makes reflects only its own offset and the trim applied so far.

The comparator has two binary-weighted trim capacitor arrays, one on each discharge node. The block drives one code into each array. The first decision is taken with both codes at zero, and it selects the side that will be trimmed. A successive-approximation search then settles the code on that side one bit per decision, starting with the most significant bit. The code on the other side stays at zero.

The search is self-timed. Each step begins when the comparator reports that it has finished its previous decision, not after a fixed number of clock cycles. Once the last bit is settled, the block releases the input short and raises a done flag. After that, a decision at the mid probability code gives a balanced 50% output.

Top module: `cmp_trim_sar`

## Requirements
- R1: While reset is high, and on the first cycle after reset, both trim codes are zero and done, input-short and strobe are all low.
- R2: A start request seen while idle or done begins a calibration. On the next cycle both codes are zero, the input short is high and the strobe is high.
- R3: The input short stays high from the start of a calibration until done rises. When done rises the input short goes low, and every strobe falls while the input short is high.
- R4: The first decision of a calibration is taken with both codes at zero and selects the side. A decision of 1 selects the positive-node code and a decision of 0 selects the negative-node code. The other code stays zero for the whole calibration.
- R5: After the side is chosen, the trial bits are tried from the MSB down to the LSB, one per decision. At each strobe the selected code holds the bits already settled above the trial bit, a 1 in the trial bit, and zeros below it.
- R6: A trial bit is kept when its decision equals the first decision of the calibration, and cleared when the decision differs. With a comparator whose decision is 1 when (offset − positive code + negative code) > 0, a positive offset ends at positive code min(offset−1, 31), and a zero or negative offset ends at negative code min(−offset, 31).
- R7: A decision is taken only in the cycle where the comparator-ready input is high after a strobe. The codes do not change while the block waits, and a ready pulse outside a calibration changes nothing.
- R8: The strobe is a one-cycle pulse. A calibration issues exactly TRIM_W+1 strobes. Done then stays high, with the codes held, until the next start.
- R9: A start request during a calibration is ignored. The calibration continues to the same result with the same strobe count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start_i | input | 1 | Start request for a calibration |
| cmp_ready_i | input | 1 | Comparator has finished the requested decision |
| cmp_dec_i | input | 1 | Comparator decision, valid while ready is high |
| cmp_strobe_o | output | 1 | One-cycle request for a comparator decision |
| cal_short_o | output | 1 | Ties both comparator inputs to common mode |
| trim_pos_o | output | TRIM_W | Trim code for the positive discharge-node array |
| trim_neg_o | output | TRIM_W | Trim code for the negative discharge-node array |
| cal_done_o | output | 1 | Calibration complete |

## Verification
A wrong side register or a wrong keep decision appears at the trim ports. It shows as a trial code that breaks the MSB-first pattern at the very next strobe, or as a final code that differs from the offset-derived value when done rises. A wrong bit index or step count shows up in the number of strobes before done, and in which bit is set at each strobe. A sequencer that accepts stray ready or start pulses corrupts the code within one cycle of the pulse, so the codes are checked right after each such pulse.

// File: rtl/trim_pkg.sv
package trim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } cal_state_t;

    typedef enum logic {
        SIDE_NEG = 1'b0,
        SIDE_POS = 1'b1
    } trim_side_t;

    typedef struct packed {
        logic take;
        logic first;
        logic dec;
    } step_ev_t;

    function automatic logic is_quiet(input cal_state_t s);
        return (s == ST_IDLE) || (s == ST_DONE);
    endfunction

endpackage

// File: rtl/trim_ctrl_fsm.sv
module trim_ctrl_fsm
    import trim_pkg::*;
#(
    parameter int TRIM_W = 5,
    parameter int IDX_W  = (TRIM_W > 1) ? $clog2(TRIM_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             ready_i,
    output cal_state_t       state_o,
    output logic             strobe_o,
    output logic             take_o,
    output logic             first_o,
    output logic             launch_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(TRIM_W - 1);

    cal_state_t       state_q;
    logic             first_q;
    logic [IDX_W-1:0] idx_q;

    assign launch_o = start_i && is_quiet(state_q);
    assign take_o   = ready_i && (state_q == ST_WAIT);
    assign strobe_o = (state_q == ST_FIRE);
    assign state_o  = state_q;
    assign first_o  = first_q;
    assign idx_o    = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            first_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start_i) begin
                        state_q <= ST_FIRE;
                        first_q <= 1'b1;
                        idx_q   <= TOP_IDX;
                    end
                end
                ST_FIRE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (ready_i) begin
                        if (first_q) begin
                            first_q <= 1'b0;
                            state_q <= ST_FIRE;
                        end else if (idx_q == '0) begin
                            state_q <= ST_DONE;
                        end else begin
                            idx_q   <= idx_q - 1'b1;
                            state_q <= ST_FIRE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2
    launch_fires_chk: assert property (@(posedge clk) disable iff (rst)
        launch_o |=> strobe_o);

    // R8
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> !strobe_o);

    // R7
    wait_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !ready_i) |=> (state_q == ST_WAIT));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && start_i && !ready_i) |=> !strobe_o);

endmodule

// File: rtl/trim_code_bank.sv
module trim_code_bank
    import trim_pkg::*;
#(
    parameter int TRIM_W = 5,
    parameter int IDX_W  = (TRIM_W > 1) ? $clog2(TRIM_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  step_ev_t          ev_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [TRIM_W-1:0] code_p_o,
    output logic [TRIM_W-1:0] code_n_o
);

    localparam int NSIDE = 2;

    trim_side_t                     side_q;
    logic [NSIDE-1:0][TRIM_W-1:0]   code_q;
    logic [TRIM_W-1:0]              sel_code;
    logic [TRIM_W-1:0]              step_next;

    assign sel_code = code_q[side_q];

    always_comb begin
        step_next = sel_code;
        if (ev_i.dec != side_q) begin
            step_next[idx_i] = 1'b0;
        end
        if (idx_i != '0) begin
            step_next[idx_i - 1'b1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            side_q <= SIDE_NEG;
        end else if (ev_i.take && ev_i.first) begin
            side_q <= trim_side_t'(ev_i.dec);
        end
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                code_q[s] <= '0;
            end else if (ev_i.take && ev_i.first) begin
                if (ev_i.dec == s[0]) begin
                    code_q[s][TRIM_W-1] <= 1'b1;
                end
            end else if (ev_i.take && (side_q == trim_side_t'(s[0]))) begin
                code_q[s] <= step_next;
            end
        end
    end

    assign code_p_o = code_q[SIDE_POS];
    assign code_n_o = code_q[SIDE_NEG];

    // R4
    one_side_chk: assert property (@(posedge clk) disable iff (rst)
        !((|code_p_o) && (|code_n_o)));

    // R6
    trial_drop_chk: assert property (@(posedge clk) disable iff (rst || clear_i)
        (ev_i.take && !ev_i.first && (ev_i.dec != side_q))
        |=> (code_q[side_q][$past(idx_i)] == 1'b0));

    // R6
    trial_keep_chk: assert property (@(posedge clk) disable iff (rst || clear_i)
        (ev_i.take && !ev_i.first && (ev_i.dec == side_q))
        |=> (code_q[side_q][$past(idx_i)] == 1'b1));

endmodule

// File: rtl/cmp_trim_sar.sv
module cmp_trim_sar
    import trim_pkg::*;
#(
    parameter int TRIM_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_start_i,
    input  logic              cmp_ready_i,
    input  logic              cmp_dec_i,
    output logic              cmp_strobe_o,
    output logic              cal_short_o,
    output logic [TRIM_W-1:0] trim_pos_o,
    output logic [TRIM_W-1:0] trim_neg_o,
    output logic              cal_done_o
);

    localparam int IDX_W = (TRIM_W > 1) ? $clog2(TRIM_W) : 1;

    cal_state_t       state;
    logic             take;
    logic             first;
    logic             launch;
    logic [IDX_W-1:0] idx;
    step_ev_t         ev;

    trim_ctrl_fsm #(.TRIM_W(TRIM_W), .IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_i  (cal_start_i),
        .ready_i  (cmp_ready_i),
        .state_o  (state),
        .strobe_o (cmp_strobe_o),
        .take_o   (take),
        .first_o  (first),
        .launch_o (launch),
        .idx_o    (idx)
    );

    assign ev = '{take: take, first: first, dec: cmp_dec_i};

    trim_code_bank #(.TRIM_W(TRIM_W), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (launch),
        .ev_i     (ev),
        .idx_i    (idx),
        .code_p_o (trim_pos_o),
        .code_n_o (trim_neg_o)
    );

    assign cal_short_o = !is_quiet(state);
    assign cal_done_o  = (state == ST_DONE);

    // R3
    strobe_shorted_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_strobe_o |-> cal_short_o);

    // R3
    done_released_chk: assert property (@(posedge clk) disable iff (rst)
        cal_done_o |-> !cal_short_o);

    // R7
    codes_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_short_o && !cmp_strobe_o && !cmp_ready_i)
        |=> ($stable(trim_pos_o) && $stable(trim_neg_o)));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_done_o && !cal_start_i) |=> (cal_done_o && $stable(trim_pos_o) && $stable(trim_neg_o)));

endmodule

// File: tb/sim_cmp_trim_sar.sv
module sim_cmp_trim_sar;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 5;
    localparam int MAXC       = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         cmp_ready;
    logic         cmp_dec;
    logic         strobe;
    logic         shorted;
    logic [W-1:0] tp;
    logic [W-1:0] tn;
    logic         done;

    logic model_rdy = 1'b0;
    logic model_dec = 1'b0;
    logic spur_rdy  = 1'b0;
    logic spur_dec  = 1'b0;

    int offset   = 0;
    int pend_cnt = 0;
    logic pend_dec = 1'b0;
    int lat_seed = 0;
    int strobe_cnt = 0;
    int trial_log [0:W];
    int tests = 0;
    int fails = 0;

    assign cmp_ready = model_rdy | spur_rdy;
    assign cmp_dec   = model_rdy ? model_dec : spur_dec;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_trim_sar #(.TRIM_W(W)) u0 (
        .clk          (clk),
        .rst          (rst),
        .cal_start_i  (start),
        .cmp_ready_i  (cmp_ready),
        .cmp_dec_i    (cmp_dec),
        .cmp_strobe_o (strobe),
        .cal_short_o  (shorted),
        .trim_pos_o   (tp),
        .trim_neg_o   (tn),
        .cal_done_o   (done)
    );

    // comparator model: decision 1 when offset - pos + neg > 0, variable latency
    initial begin
        forever begin
            @(negedge clk);
            model_rdy = 1'b0;
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    model_rdy = 1'b1;
                    model_dec = pend_dec;
                end
            end
            if (strobe) begin
                pend_dec = ((offset - int'(tp) + int'(tn)) > 0);
                if (strobe_cnt <= W) trial_log[strobe_cnt] = int'(tp) | int'(tn);
                strobe_cnt++;
                pend_cnt = 1 + (lat_seed % 4);
                lat_seed++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (offset %0d)", req, act, exp, offset);
        end
    endtask

    task automatic run_cal(input int off, input bit poke_start);
        int exp_p;
        int exp_n;
        int fin;
        int cyc;
        bit short_ok;
        offset = off;
        strobe_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: cleared codes, short high, strobe high
        chk(tp == 0 && tn == 0, "R2 codes cleared", int'(tp) | int'(tn), 0);
        chk(shorted == 1'b1, "R2 short", int'(shorted), 1);
        chk(strobe == 1'b1, "R2 strobe", int'(strobe), 1);
        short_ok = 1'b1;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (poke_start && cyc == 6) start = 1'b1;   // R9
            else start = 1'b0;
            if (!done && !shorted) short_ok = 1'b0;
        end
        start = 1'b0;
        chk(short_ok, "R3 short held", int'(short_ok), 1);
        chk(shorted == 1'b0, "R3 short released", int'(shorted), 0);
        exp_p = (off > 0) ? ((off - 1 > MAXC) ? MAXC : off - 1) : 0;
        exp_n = (off > 0) ? 0 : ((-off > MAXC) ? MAXC : -off);
        chk(int'(tp) == exp_p, "R6 pos code", int'(tp), exp_p);
        chk(int'(tn) == exp_n, "R4/R6 neg code", int'(tn), exp_n);
        chk(strobe_cnt == W + 1, poke_start ? "R9 strobe count" : "R8 strobe count", strobe_cnt, W + 1);
        fin = exp_p | exp_n;
        chk(trial_log[0] == 0, "R4 first decision untrimmed", trial_log[0], 0);
        for (int k = 1; k <= W; k++) begin
            int b;
            int e;
            b = W - k;
            e = ((fin >> (b + 1)) << (b + 1)) | (1 << b);
            chk(trial_log[k] == e, "R5 trial pattern", trial_log[k], e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        chk(tp == 0 && tn == 0, "R1 codes in reset", int'(tp) | int'(tn), 0);
        chk(!done && !shorted && !strobe, "R1 flags in reset", int'({done, shorted, strobe}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !shorted && !strobe && tp == 0 && tn == 0, "R1 after reset",
            int'({done, shorted, strobe}), 0);

        // R7: stray ready while idle changes nothing
        spur_dec = 1'b1;
        spur_rdy = 1'b1;
        @(negedge clk);
        spur_rdy = 1'b0;
        @(negedge clk);
        chk(tp == 0 && tn == 0 && !shorted && !strobe, "R7 idle stray ready", int'(tp) | int'(tn), 0);

        for (int off = -40; off <= 40; off++) begin
            run_cal(off, (off % 7) == 0);
            // R8: done holds with codes
            begin
                logic [W-1:0] hp;
                logic [W-1:0] hn;
                int sc;
                hp = tp; hn = tn; sc = strobe_cnt;
                spur_dec = ~spur_dec;
                spur_rdy = 1'b1;    // R7 stray ready after done
                @(negedge clk);
                spur_rdy = 1'b0;
                repeat (3) @(negedge clk);
                chk(done == 1'b1, "R8 done held", int'(done), 1);
                chk(tp == hp && tn == hn, "R7 codes after stray ready", int'(tp) | int'(tn), int'(hp) | int'(hn));
                chk(strobe_cnt == sc, "R8 no extra strobes", strobe_cnt, sc);
            end
        end

        // R1: reset mid-calibration returns to idle
        offset = 9;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tp == 0 && tn == 0, "R1 codes after abort", int'(tp) | int'(tn), 0);
        chk(!done && !shorted, "R1 flags after abort", int'({done, shorted}), 0);
        repeat (10) @(negedge clk);
        chk(tp == 0 && tn == 0 && !shorted, "R7 late ready after abort", int'(tp) | int'(tn), 0);

        run_cal(-3, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule